// File: doc/BRIEF.md
# Loopback UART Register File

This block is the register front end of a 16550-style serial port with no serial line behind it. Every byte written to the transmit data register goes straight into a 16-entry circular receive queue, and reading the data register takes bytes back out in the order they went in. Because the same queue serves both directions, all status information comes from how full that one queue is. This covers the interrupt identification, the line status and the modem status.

Software reaches eight byte-wide registers through a 3-bit offset with separate read and write strobes. It can program a 16-bit baud divisor, change the queue depth between 16 and 1, pick the receive interrupt threshold and clear the queue. Whenever an interrupt-worthy event happens, the block raises a one-cycle event pulse. Read data is combinational from the current state while the read strobe is high. The side effects of an access, such as a pop, a push or an interrupt pulse, take effect at the clock edge that ends it.

Top module: `loopuart_regs`

## Requirements
- R1: A write to offset 0 while line-control bit 7 is clear appends the byte when the fill count is below the capacity and clears the overrun flag. When the count has reached the capacity, the byte is dropped, the count holds and the overrun flag is set.
- R2: A read of offset 0 while line-control bit 7 is clear returns the oldest stored byte and removes it. Reading an empty queue returns 0x00 and changes nothing.
- R3: Writing offset 3 with bit 7 set enters divisor mode and clears the divisor. In that mode, offsets 0 and 1 write and read the divisor's low and high bytes, and they touch neither the queue nor the interrupt enables.
- R4: A write to offset 2 sets the receive threshold from bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. Bit 1 or bit 2 empties the queue. With bit 0 clear, the capacity becomes 1 and the threshold becomes 1; with bit 0 set, the capacity is 16.
- R5: An event pulse fires in three queue cases. The first is a push that makes the count equal the threshold while enable bit 0 (received data) is set. The second is an overrun while enable bit 2 (line status) is set. The third is a pop that leaves the queue empty while enable bit 1 (transmit empty) is set.
- R6: Writing offset 1 with bit 1 set while the queue is empty fires an event pulse. Writing offset 4 with bit 0, 1 or 3 set while enable bit 3 (modem status) is set also fires one.
- R7: Reading offset 2 gives 0x6 in its low nibble when overrun is set and line-status interrupts are enabled. Failing that, it gives 0x4 when received-data interrupts are enabled and the count is at or above the threshold. Failing that, it gives 0x2 when transmit-empty interrupts are enabled and the queue is empty. Failing that, it gives 0x0 when modem-status interrupts are enabled and offset 4 bit 0 or 1 is set. Otherwise it gives 0x1.
- R8: Bits 7:6 of the offset 2 read value are both 1 while the queue is enabled (capacity 16) and both 0 when it is disabled.
- R9: Offset 5 reads bit 0 = queue not empty, bit 1 = overrun, and bits 5 and 6 = queue empty; all other bits are 0.
- R10: Offset 6 reads 0xB3 when offset 4 bit 5 (auto-flow) is clear or the queue has room, and 0xA2 when auto-flow is set and the queue is at capacity.
- R11: Offset 1 reads back only the low four bits written to it. Offsets 3, 4 and 7 read back the full byte last written.
- R12: After reset the queue is empty, with capacity 16 and threshold 1. All enables, control registers and the divisor are zero, the event output is low, offset 2 reads 0xC1, offset 5 reads 0x60 and offset 6 reads 0xB3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe, one access per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq_pulse | output | 1 | One-cycle interrupt event, registered |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. The queue and the interrupt logic count on one access per cycle, so a push and a pop never coincide. The stimulus drives every access as a single-cycle strobe followed by at least one idle cycle, so that condition always holds. The same spacing keeps each event pulse apart from the next, which lets the pulses be counted one access at a time.

// File: rtl/loopuart_pkg.sv
package loopuart_pkg;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_IID   = 3'd2;
  localparam logic [2:0] OFS_LCTL  = 3'd3;
  localparam logic [2:0] OFS_MCTL  = 3'd4;
  localparam logic [2:0] OFS_LSTAT = 3'd5;
  localparam logic [2:0] OFS_MSTAT = 3'd6;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  localparam int IEN_RXD   = 0;
  localparam int IEN_TXE   = 1;
  localparam int IEN_LINE  = 2;
  localparam int IEN_MODEM = 3;

  typedef struct packed {
    logic ovr;
    logic rxd;
    logic txe;
    logic mst;
  } irq_src_t;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    logic [4:0] lvl;
    case (sel)
      2'b00:   lvl = 5'd1;
      2'b01:   lvl = 5'd4;
      2'b10:   lvl = 5'd8;
      default: lvl = 5'd14;
    endcase
    return lvl;
  endfunction

  function automatic logic [7:0] iid_code(input irq_src_t p, input logic fifo_on);
    logic [3:0] c;
    if (p.ovr)      c = 4'h6;
    else if (p.rxd) c = 4'h4;
    else if (p.txe) c = 4'h2;
    else if (p.mst) c = 4'h0;
    else            c = 4'h1;
    return {fifo_on, fifo_on, 2'b00, c};
  endfunction

  function automatic logic [7:0] lsr_byte(input logic nonempty, input logic ovr);
    return {1'b0, ~nonempty, ~nonempty, 3'b000, ovr, nonempty};
  endfunction

  function automatic logic [7:0] msr_byte(input logic cts);
    return {1'b1, 1'b0, 1'b1, cts, 2'b00, 1'b1, cts};
  endfunction

endpackage

// File: rtl/loopuart_fifo.sv
module loopuart_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          accept,
  output logic          reject,
  output logic          pop_ok
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head_q, tail_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (count == '0);
  assign accept = push && !flush && (count < cap);
  assign reject = push && !flush && !(count < cap);
  assign pop_ok = pop && !flush && !empty;
  assign dout   = empty ? '0 : mem[tail_q];

  always_ff @(posedge clk) begin
    if (accept) mem[head_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      count  <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
      count  <= '0;
    end else begin
      if (accept) head_q <= bump(head_q);
      if (pop_ok) tail_q <= bump(tail_q);
      case ({accept, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    reject && !pop |=> count == $past(count)); // R1
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push && !flush |=> count == '0); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R4

endmodule

// File: rtl/loopuart_irq.sv
module loopuart_irq
  import loopuart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ien,
  input  logic       fifo_on,
  input  logic       ovr_flag,
  input  logic       rx_at_level,
  input  logic       rx_empty,
  input  logic       modem_req,
  input  logic       ev_rx_level,
  input  logic       ev_overrun,
  input  logic       ev_drain,
  input  logic       ev_txe_enable,
  input  logic       ev_modem_wr,
  output logic [7:0] iid,
  output logic       irq_pulse
);

  irq_src_t pend;
  logic     fire;

  always_comb begin
    pend.ovr = ien[IEN_LINE]  & ovr_flag;
    pend.rxd = ien[IEN_RXD]   & rx_at_level;
    pend.txe = ien[IEN_TXE]   & rx_empty;
    pend.mst = ien[IEN_MODEM] & modem_req;
  end

  assign iid = iid_code(pend, fifo_on);

  assign fire = (ien[IEN_RXD]   & ev_rx_level)
              | (ien[IEN_LINE]  & ev_overrun)
              | (ien[IEN_TXE]   & ev_drain)
              | ev_txe_enable
              | (ien[IEN_MODEM] & ev_modem_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= fire;
  end

  AST_IID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ien == 4'h0 |-> iid[3:0] == 4'h1); // R7
  AST_OVR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ien[IEN_LINE] && ovr_flag |-> iid[3:0] == 4'h6); // R7

endmodule

// File: rtl/loopuart_regs.sv
module loopuart_regs
  import loopuart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_pulse
);

  logic [3:0]    ien_q;
  logic [7:0]    lcr_q, mcr_q, scr_q;
  logic [15:0]   div_q;
  logic          fifo_on_q;
  logic [4:0]    thr_q;
  logic          ovr_q;
  logic          dlab;

  logic          push, pop, flush;
  logic          accept, reject, pop_ok, empty;
  logic [CW-1:0] cnt, cap;
  logic [7:0]    head_byte, iid;

  logic          ev_rx_level, ev_drain, ev_txe_enable, ev_modem_wr;
  logic          rx_at_level, modem_req, cts;

  assign dlab  = lcr_q[7];
  assign cap   = fifo_on_q ? CW'(FIFO_DEPTH) : CW'(1);
  assign push  = reg_wr && (reg_addr == OFS_DATA) && !dlab;
  assign pop   = reg_rd && (reg_addr == OFS_DATA) && !dlab;
  assign flush = reg_wr && (reg_addr == OFS_IID) && (reg_wdata[1] | reg_wdata[2]);

  loopuart_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .flush  (flush),
    .cap    (cap),
    .din    (reg_wdata),
    .dout   (head_byte),
    .count  (cnt),
    .empty  (empty),
    .accept (accept),
    .reject (reject),
    .pop_ok (pop_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q     <= '0;
      lcr_q     <= '0;
      mcr_q     <= '0;
      scr_q     <= '0;
      div_q     <= '0;
      fifo_on_q <= 1'b1;
      thr_q     <= 5'd1;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_DATA: if (dlab) div_q[7:0] <= reg_wdata;
        OFS_IEN: begin
          if (dlab) div_q[15:8] <= reg_wdata;
          else      ien_q       <= reg_wdata[3:0];
        end
        OFS_IID: begin
          fifo_on_q <= reg_wdata[0];
          thr_q     <= reg_wdata[0] ? trig_level(reg_wdata[7:6]) : 5'd1;
        end
        OFS_LCTL: begin
          lcr_q <= reg_wdata;
          if (reg_wdata[7]) div_q <= '0;
        end
        OFS_MCTL: mcr_q <= reg_wdata;
        OFS_SCR:  scr_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (accept) ovr_q <= 1'b0;
    else if (reject) ovr_q <= 1'b1;
  end

  assign ev_rx_level   = accept && ((32'(cnt) + 1) == 32'(thr_q));
  assign ev_drain      = pop_ok && (cnt == CW'(1));
  assign ev_txe_enable = reg_wr && (reg_addr == OFS_IEN) && !dlab && reg_wdata[1] && empty;
  assign ev_modem_wr   = reg_wr && (reg_addr == OFS_MCTL) &&
                         (reg_wdata[0] | reg_wdata[1] | reg_wdata[3]);
  assign rx_at_level   = 32'(cnt) >= 32'(thr_q);
  assign modem_req     = mcr_q[0] | mcr_q[1];
  assign cts           = !mcr_q[5] || (cnt < cap);

  loopuart_irq u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ien           (ien_q),
    .fifo_on       (fifo_on_q),
    .ovr_flag      (ovr_q),
    .rx_at_level   (rx_at_level),
    .rx_empty      (empty),
    .modem_req     (modem_req),
    .ev_rx_level   (ev_rx_level),
    .ev_overrun    (reject),
    .ev_drain      (ev_drain),
    .ev_txe_enable (ev_txe_enable),
    .ev_modem_wr   (ev_modem_wr),
    .iid           (iid),
    .irq_pulse     (irq_pulse)
  );

  always_comb begin
    case (reg_addr)
      OFS_DATA:  reg_rdata = dlab ? div_q[7:0]  : head_byte;
      OFS_IEN:   reg_rdata = dlab ? div_q[15:8] : {4'h0, ien_q};
      OFS_IID:   reg_rdata = iid;
      OFS_LCTL:  reg_rdata = lcr_q;
      OFS_MCTL:  reg_rdata = mcr_q;
      OFS_LSTAT: reg_rdata = lsr_byte(!empty, ovr_q);
      OFS_MSTAT: reg_rdata = msr_byte(cts);
      default:   reg_rdata = scr_q;
    endcase
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R2
  AST_DLAB_CLEARS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == OFS_LCTL) && reg_wdata[7] |=> div_q == 16'h0); // R3
  AST_DIV_SKIPS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == OFS_DATA) && dlab |=> $stable(cnt)); // R3
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ovr_q); // R1

endmodule

// File: tb/loopuart_regs_bench.sv
module loopuart_regs_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_pulse;

  int errors = 0;
  int checks = 0;
  int irq_seen = 0;
  int irq_base = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  loopuart_regs u_loopuart_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_pulse (irq_pulse)
  );

  // Monitor: counts event pulses and compares each read against the scoreboard.
  always @(negedge clk) begin
    if (irq_pulse) irq_seen++;
    if (reg_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, actual=%02h expected=none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic irq_chk(input int n, input string t);
    @(posedge clk); #1;
    checks++;
    if (irq_seen - irq_base != n) begin
      errors++;
      $display("FAIL %s: irq pulses actual=%0d expected=%0d", t, irq_seen - irq_base, n);
    end
    irq_base = irq_seen;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    irq_chk(0, "R12 idle event");
    rd(3'd2, 8'hC1, "R12 iid reset");
    rd(3'd5, 8'h60, "R12 lsr reset");
    rd(3'd6, 8'hB3, "R12 msr reset");
    rd(3'd0, 8'h00, "R2 empty read");
    rd(3'd1, 8'h00, "R12 ien reset");

    // R11 readback
    wr(3'd3, 8'h03); rd(3'd3, 8'h03, "R11 lcr");
    wr(3'd7, 8'h5A); rd(3'd7, 8'h5A, "R11 scratch");
    wr(3'd1, 8'hF0); rd(3'd1, 8'h00, "R11 ien nibble");
    irq_chk(0, "R11 no event");

    // R3 divisor
    wr(3'd3, 8'h83); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R3 div low");
    rd(3'd1, 8'h12, "R3 div high");
    rd(3'd5, 8'h60, "R3 fifo untouched");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h00, "R3 ien untouched");
    wr(3'd3, 8'h83);
    rd(3'd0, 8'h00, "R3 div cleared low");
    rd(3'd1, 8'h00, "R3 div cleared high");
    wr(3'd3, 8'h03);

    // R1/R2 ordering
    wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
    rd(3'd5, 8'h01, "R9 lsr data");
    rd(3'd0, 8'h11, "R2 pop 1");
    rd(3'd0, 8'h22, "R2 pop 2");
    rd(3'd0, 8'h33, "R2 pop 3");
    rd(3'd5, 8'h60, "R9 lsr empty");

    // R1 overrun with wrap
    for (int i = 0; i < 16; i++) wr(3'd0, 8'(8'h40 + i));
    rd(3'd5, 8'h01, "R9 lsr full");
    wr(3'd0, 8'h99);
    rd(3'd5, 8'h03, "R1 overrun lsr");
    for (int i = 0; i < 16; i++) rd(3'd0, 8'(8'h40 + i), "R1 kept order");
    rd(3'd0, 8'h00, "R2 empty after drain");
    rd(3'd5, 8'h62, "R9 empty with overrun");
    wr(3'd0, 8'h77);
    rd(3'd5, 8'h01, "R1 push clears overrun");
    rd(3'd0, 8'h77, "R2 pop after overrun");
    irq_chk(0, "R5 no enables");

    // R10 auto-flow
    wr(3'd4, 8'h20);
    rd(3'd6, 8'hB3, "R10 room");
    for (int i = 0; i < 16; i++) wr(3'd0, 8'(i));
    rd(3'd6, 8'hA2, "R10 full");
    wr(3'd0, 8'hEE);
    rd(3'd5, 8'h03, "R1 overrun again");
    wr(3'd2, 8'h07);
    rd(3'd5, 8'h62, "R4 clear keeps overrun");
    rd(3'd6, 8'hB3, "R10 room after clear");
    wr(3'd0, 8'h01); rd(3'd0, 8'h01, "R2 single");
    wr(3'd4, 8'h00);
    rd(3'd4, 8'h00, "R11 mcr");

    // R4/R5 thresholds
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h41);
    for (int i = 0; i < 3; i++) wr(3'd0, 8'(i));
    irq_chk(0, "R4 below level 4");
    wr(3'd0, 8'h03);
    irq_chk(1, "R5 level 4 reached");
    rd(3'd2, 8'hC4, "R7 rx data");
    wr(3'd0, 8'h04);
    irq_chk(0, "R5 past level");
    wr(3'd2, 8'h87);
    rd(3'd5, 8'h60, "R4 clear empties");
    for (int i = 0; i < 7; i++) wr(3'd0, 8'(i));
    irq_chk(0, "R4 below level 8");
    wr(3'd0, 8'h07);
    irq_chk(1, "R4 level 8");
    wr(3'd2, 8'hC7);
    for (int i = 0; i < 13; i++) wr(3'd0, 8'(i));
    irq_chk(0, "R4 below level 14");
    wr(3'd0, 8'h0D);
    irq_chk(1, "R4 level 14");
    wr(3'd2, 8'h07);

    // R4/R8 queue disabled
    wr(3'd2, 8'h00);
    rd(3'd2, 8'h01, "R8 disabled idle");
    wr(3'd0, 8'hAA);
    irq_chk(1, "R4 level 1 when disabled");
    wr(3'd0, 8'hBB);
    irq_chk(0, "R5 overrun masked");
    rd(3'd5, 8'h03, "R4 capacity one");
    rd(3'd2, 8'h04, "R8 disabled rx code");
    rd(3'd0, 8'hAA, "R4 kept first");
    rd(3'd0, 8'h00, "R4 second dropped");
    wr(3'd2, 8'h01);

    // R7 overrun priority, R5 overrun event
    wr(3'd1, 8'h05);
    rd(3'd2, 8'hC6, "R7 overrun code");
    irq_chk(0, "R6 no txe bit");
    wr(3'd0, 8'h01);
    irq_chk(1, "R5 level 1");
    wr(3'd1, 8'h04);
    for (int i = 0; i < 15; i++) wr(3'd0, 8'(i));
    irq_chk(0, "R5 rxd disabled");
    wr(3'd0, 8'hFF);
    irq_chk(1, "R5 overrun event");
    wr(3'd2, 8'h07);
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h00, "R2 pop zero byte");
    irq_chk(0, "R5 drain masked");

    // R5/R6 transmit empty
    wr(3'd1, 8'h02);
    irq_chk(1, "R6 txe enable while empty");
    wr(3'd0, 8'h05);
    irq_chk(0, "R5 push no txe");
    rd(3'd2, 8'hC1, "R7 not empty none");
    rd(3'd0, 8'h05, "R2 pop last");
    irq_chk(1, "R5 drain event");
    rd(3'd2, 8'hC2, "R7 txe code");
    rd(3'd0, 8'h00, "R2 empty again");
    irq_chk(0, "R5 no drain on empty");

    // R6/R7 modem
    wr(3'd1, 8'h08);
    irq_chk(0, "R6 ien without txe");
    rd(3'd2, 8'hC1, "R7 modem idle");
    wr(3'd4, 8'h08);
    irq_chk(1, "R6 out2");
    rd(3'd2, 8'hC1, "R7 out2 no code");
    wr(3'd4, 8'h02);
    irq_chk(1, "R6 rts");
    rd(3'd2, 8'hC0, "R7 modem code");
    wr(3'd4, 8'h20);
    irq_chk(0, "R6 afe only");
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h03);
    irq_chk(0, "R6 modem masked");
    rd(3'd4, 8'h03, "R11 mcr full");

    // R7 full priority ladder
    wr(3'd1, 8'h0F);
    irq_chk(1, "R6 txe with all enables");
    rd(3'd2, 8'hC2, "R7 txe over modem");
    wr(3'd0, 8'h10);
    irq_chk(1, "R5 level with all");
    rd(3'd2, 8'hC4, "R7 rxd over txe");
    for (int i = 0; i < 15; i++) wr(3'd0, 8'(i));
    irq_chk(0, "R5 no extra");
    wr(3'd0, 8'h20);
    irq_chk(1, "R5 overrun with all");
    rd(3'd2, 8'hC6, "R7 overrun first");
    wr(3'd2, 8'h07);
    wr(3'd1, 8'h00);

    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule